// File: doc/BRIEF.md
# Per-line edge/level interrupt request capture

This block samples a set of synchronous interrupt request lines and keeps a pending-request vector for a downstream priority and acknowledge stage. A trigger-select register sets each line to level behaviour (1) or edge behaviour (0). A level line's pending bit tracks the input one cycle late. An edge line latches a rising transition and keeps it until something clears it. Software can write the trigger-select register, but only the bits set in the fixed parameter `WR_MASK` can take a 1. The other bits always read 0, so those lines are permanently edge-triggered. With the default of 0xF8, lines 0 to 2 are edge-only. A second instance would use 0xDE.

Each line is its own four-state machine. The state holds two things: the level seen in the previous cycle and the pending flag. The states are:

- `S_LO_IDLE`: previous level low, not pending.
- `S_LO_PEND`: previous level low, pending.
- `S_HI_IDLE`: previous level high, not pending.
- `S_HI_PEND`: previous level high, pending.

The transitions are:

- "rise": a high input reaches a `*_PEND` state.
- "fall": a low input drops to `S_LO_*`. In level mode it always goes to `S_LO_IDLE`. In edge mode the pending flag is kept.
- "ack": the clear bit wins and selects the `*_IDLE` state of the current input level.
- "init": the initialization pulse goes to `S_LO_IDLE`.

The controller uses the clear vector to drop pending bits when a request is acknowledged or serviced. It uses the initialization pulse to restart capture without losing the trigger-select settings.

Top module: `irq_req_capture`

## Requirements
- R1: After the synchronous reset `rst`, `pend_out` is 0 and `tsel_rdata` is 0.
- R2: For a line whose trigger-select bit is 1 (level), `pend_out[i]` after a clock edge equals the value of `req_in[i]` at that edge, unless `clr_vec[i]` is high at that edge.
- R3: For a line whose trigger-select bit is 0 (edge), the pending bit is set only when `req_in[i]` is 1 at an edge where it was 0 at the previous edge. If the input stays high, the bit is not set again after it is cleared.
- R4: For an edge line, a low input does not clear a pending bit that is already set.
- R5: When `tsel_we` is 1 at a clock edge, the trigger-select register takes `tsel_wdata & WR_MASK` and `tsel_rdata` shows it after that edge. When `tsel_we` is 0, the register holds its value. With the default mask 0xF8, bits 0 to 2 always read 0.
- R6: A 1 in `clr_vec[i]` at an edge clears `pend_out[i]` after that edge in either mode. The clear wins over a set in the same cycle.
- R7: A pulse on `init_clr` clears all pending and previous-level bits but keeps the trigger-select register. An edge line held high through the pulse is therefore captured again one cycle after it.
- R8: The previous-level bit is tracked in both modes. A line switched from level to edge while its input stays high does not see a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_clr | input | 1 | Initialization pulse: clears pending and previous-level state |
| req_in | input | N_LINES | Raw request lines, synchronous to clk |
| clr_vec | input | N_LINES | Pending bits to clear this cycle |
| tsel_we | input | 1 | Trigger-select write enable |
| tsel_wdata | input | N_LINES | Trigger-select write value (1 = level, 0 = edge) |
| tsel_rdata | output | N_LINES | Trigger-select readback |
| pend_out | output | N_LINES | Pending-request vector |

## Verification
The hardest situation to reach is a pending edge line whose input has gone back to 0. It only arises after an earlier rise that was neither cleared nor reinitialised, so the stimulus table first raises every line and then drops the inputs without a clear. A second hard case is an edge line whose previous level is high while it is not pending. This state needs a clear, or a switch from level to edge mode, while the input is held high. Directed steps build it both ways: a clear during a held input, and a mode write plus a clear in the same cycle. They then confirm that no false edge follows. A further step holds an input high through the initialization pulse to show that the edge is captured again.

// File: rtl/irq_req_capture_pkg.sv
package irq_req_capture_pkg;

    // Per-line capture state: {previous level, pending}
    typedef enum logic [1:0] {
        S_LO_IDLE = 2'b00,
        S_LO_PEND = 2'b01,
        S_HI_IDLE = 2'b10,
        S_HI_PEND = 2'b11
    } line_state_e;

endpackage

// File: rtl/irq_req_capture_line.sv
module irq_req_capture_line
    import irq_req_capture_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init_clr,
    input  logic req,
    input  logic clr,
    input  logic level_mode,
    output logic pend,
    output logic prev
);

    line_state_e state_q;
    line_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_LO_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (init_clr) begin
            state_d = S_LO_IDLE;
        end else begin
            unique case (state_q)
                S_LO_IDLE: begin
                    if (req) state_d = clr ? S_HI_IDLE : S_HI_PEND;
                    else     state_d = S_LO_IDLE;
                end
                S_LO_PEND: begin
                    if (req)             state_d = clr ? S_HI_IDLE : S_HI_PEND;
                    else if (level_mode) state_d = S_LO_IDLE;
                    else                 state_d = clr ? S_LO_IDLE : S_LO_PEND;
                end
                S_HI_IDLE: begin
                    if (!req)            state_d = S_LO_IDLE;
                    else if (level_mode) state_d = clr ? S_HI_IDLE : S_HI_PEND;
                    else                 state_d = S_HI_IDLE;
                end
                S_HI_PEND: begin
                    if (req)             state_d = clr ? S_HI_IDLE : S_HI_PEND;
                    else if (level_mode) state_d = S_LO_IDLE;
                    else                 state_d = clr ? S_LO_IDLE : S_LO_PEND;
                end
                default: state_d = S_LO_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        pend = 1'b0;
        prev = 1'b0;
        unique case (state_q)
            S_LO_IDLE: begin pend = 1'b0; prev = 1'b0; end
            S_LO_PEND: begin pend = 1'b1; prev = 1'b0; end
            S_HI_IDLE: begin pend = 1'b0; prev = 1'b1; end
            S_HI_PEND: begin pend = 1'b1; prev = 1'b1; end
            default:   begin pend = 1'b0; prev = 1'b0; end
        endcase
    end

    // R2: level line follows input one cycle later
    p_level_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (!init_clr && level_mode) |=> (pend == $past(req && !clr)));

    // R3: edge line sets on a rise
    p_edge_set_r3: assert property (@(posedge clk) disable iff (rst)
        (!init_clr && !level_mode && req && !prev && !clr) |=> pend);

    // R3: edge line without a rise stays idle
    p_edge_noset_r3: assert property (@(posedge clk) disable iff (rst)
        (!init_clr && !level_mode && !pend && !(req && !prev)) |=> !pend);

    // R4: low input keeps an edge pending bit
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!init_clr && !level_mode && !req && pend && !clr) |=> pend);

    // R6: clear wins in any mode
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (!init_clr && clr) |=> !pend);

    // R7: init empties the line
    p_init_empty_r7: assert property (@(posedge clk) disable iff (rst)
        init_clr |=> (!pend && !prev));

    // R8: previous level tracks the input in both modes
    p_prev_track_r8: assert property (@(posedge clk) disable iff (rst)
        !init_clr |=> (prev == $past(req)));

endmodule

// File: rtl/irq_req_capture_tsel.sv
module irq_req_capture_tsel #(
    parameter int N_LINES = 8,
    parameter logic [N_LINES-1:0] WR_MASK = 8'hF8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [N_LINES-1:0] wdata,
    output logic [N_LINES-1:0] tsel
);

    logic [N_LINES-1:0] tsel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tsel_q <= '0;
        end else if (we) begin
            tsel_q <= wdata & WR_MASK;
        end
    end

    assign tsel = tsel_q;

    // R5: write stores the masked value
    p_tsel_write_r5: assert property (@(posedge clk) disable iff (rst)
        we |=> (tsel == $past(wdata & WR_MASK)));

    // R5: register holds without a write
    p_tsel_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(tsel));

    // R1: reset clears the register
    p_tsel_reset_r1: assert property (@(posedge clk)
        rst |=> (tsel == '0));

endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int N_LINES = 8,
    parameter logic [N_LINES-1:0] WR_MASK = 8'hF8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_clr,
    input  logic [N_LINES-1:0] req_in,
    input  logic [N_LINES-1:0] clr_vec,
    input  logic               tsel_we,
    input  logic [N_LINES-1:0] tsel_wdata,
    output logic [N_LINES-1:0] tsel_rdata,
    output logic [N_LINES-1:0] pend_out
);

    logic [N_LINES-1:0] tsel;
    logic [N_LINES-1:0] prev_lvl;

    irq_req_capture_tsel #(
        .N_LINES (N_LINES),
        .WR_MASK (WR_MASK)
    ) u_tsel (
        .clk   (clk),
        .rst   (rst),
        .we    (tsel_we),
        .wdata (tsel_wdata),
        .tsel  (tsel)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        irq_req_capture_line u_line (
            .clk        (clk),
            .rst        (rst),
            .init_clr   (init_clr),
            .req        (req_in[i]),
            .clr        (clr_vec[i]),
            .level_mode (tsel[i]),
            .pend       (pend_out[i]),
            .prev       (prev_lvl[i])
        );
    end

    assign tsel_rdata = tsel;

    // R1: reset empties all pending bits
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (pend_out == '0 && prev_lvl == '0));

    // R7: init keeps the trigger-select register
    p_init_keeps_tsel_r7: assert property (@(posedge clk) disable iff (rst)
        (init_clr && !tsel_we) |=> $stable(tsel_rdata));

endmodule

// File: tb/irq_req_capture_bench.sv
`timescale 1ns/1ps
module irq_req_capture_bench;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         init_clr = 1'b0;
    logic [N-1:0] req_in = '0;
    logic [N-1:0] clr_vec = '0;
    logic         tsel_we = 1'b0;
    logic [N-1:0] tsel_wdata = '0;
    logic [N-1:0] tsel_rdata;
    logic [N-1:0] pend_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_req_capture u_irq_req_capture (
        .clk        (clk),
        .rst        (rst),
        .init_clr   (init_clr),
        .req_in     (req_in),
        .clr_vec    (clr_vec),
        .tsel_we    (tsel_we),
        .tsel_wdata (tsel_wdata),
        .tsel_rdata (tsel_rdata),
        .pend_out   (pend_out)
    );

    // {req, clr, expected pend}; tsel = 0xF8: lines 0..2 edge, 3..7 level
    localparam logic [23:0] VEC_TBL [0:12] = '{
        24'h00_00_00,
        24'hFF_00_FF,
        24'h07_00_07,
        24'h00_00_07,
        24'h00_01_06,
        24'h01_00_07,
        24'h01_01_06,
        24'h01_00_06,
        24'h02_02_04,
        24'h02_00_04,
        24'h18_08_14,
        24'h18_00_1C,
        24'h00_04_00
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic [N-1:0] c,
                        input logic we, input logic [N-1:0] wd, input logic ini);
        @(negedge clk);
        req_in = r; clr_vec = c; tsel_we = we; tsel_wdata = wd; init_clr = ini;
        @(posedge clk);
        #1;
        tsel_we = 1'b0; init_clr = 1'b0; clr_vec = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 checked while still in reset, and after release
        check("R1 pend in reset", pend_out, 8'h00);
        check("R1 tsel in reset", tsel_rdata, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        step(8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
        check("R1 pend after reset", pend_out, 8'h00);

        // R5: masked writes
        step(8'h00, 8'h00, 1'b1, 8'h5A, 1'b0);
        check("R5 write 5A", tsel_rdata, 8'h58);
        step(8'h00, 8'h00, 1'b0, 8'hFF, 1'b0);
        check("R5 hold without we", tsel_rdata, 8'h58);
        step(8'h00, 8'h00, 1'b1, 8'hFF, 1'b0);
        check("R5 write FF masked", tsel_rdata, 8'hF8);

        // Table walk: R2 R3 R4 R6
        for (int k = 0; k < 13; k++) begin
            step(VEC_TBL[k][23:16], VEC_TBL[k][15:8], 1'b0, 8'h00, 1'b0);
            check($sformatf("R2/R3/R4/R6 vector %0d", k), pend_out, VEC_TBL[k][7:0]);
        end

        // R7: init keeps tsel, edge line held high is recaptured
        step(8'h00, 8'hFF, 1'b1, 8'h80, 1'b0);
        check("R7 setup tsel", tsel_rdata, 8'h80);
        step(8'h81, 8'h00, 1'b0, 8'h00, 1'b0);
        check("R7 setup pend", pend_out, 8'h81);
        step(8'h81, 8'h00, 1'b0, 8'h00, 1'b1);
        check("R7 init clears pend", pend_out, 8'h00);
        check("R7 init keeps tsel", tsel_rdata, 8'h80);
        step(8'h81, 8'h00, 1'b0, 8'h00, 1'b0);
        check("R7 edge recaptured after init", pend_out, 8'h81);

        // R8: level -> edge switch with input held high
        step(8'h00, 8'hFF, 1'b1, 8'h08, 1'b0);
        step(8'h08, 8'h00, 1'b0, 8'h00, 1'b0);
        check("R8 level line pending", pend_out, 8'h08);
        step(8'h08, 8'h08, 1'b1, 8'h00, 1'b0);
        check("R8 switch and clear", pend_out, 8'h00);
        check("R8 tsel now edge", tsel_rdata, 8'h00);
        step(8'h08, 8'h00, 1'b0, 8'h00, 1'b0);
        step(8'h08, 8'h00, 1'b0, 8'h00, 1'b0);
        check("R8 no false edge", pend_out, 8'h00);
        step(8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
        step(8'h08, 8'h00, 1'b0, 8'h00, 1'b0);
        check("R3 real edge after low", pend_out, 8'h08);

        // R1: reset again from a busy state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 re-reset pend", pend_out, 8'h00);
        check("R1 re-reset tsel", tsel_rdata, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule